// File: doc/BRIEF.md
# Exclusive Access Monitor

This block watches exclusive read/write pairs on a write-capable memory port and decides, for every exclusive write, whether the location it targets is still unmodified since that ID's exclusive read. It can hold up to four reservations at once, each tied to a transaction ID and an address. Every write that really updates memory is checked against the reservations held by other IDs. A reservation whose address falls inside the written region is dropped.

The write region is worked out conservatively. The burst is always assumed to be incrementing. The first and last byte addresses of the write are compared, and every address bit up to one position above the highest bit that differs is left out of the comparison. This can report a conflict that did not happen, but it never misses a real one.

Each write presented on the check port produces a registered result one cycle later. A plain write keeps its byte strobes and gets a normal okay. An exclusive write that passes gets exclusive-okay and keeps its strobes. An exclusive write that fails gets a normal okay and has all strobes forced to zero, so memory is left untouched.

Top module: `excl_monitor`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is 0 and no reservation is held, so the first exclusive write after reset fails.
- R2: `res_valid` is high in exactly the cycle after a cycle with `wr_valid` high, and low otherwise.
- R3: A write with `wr_excl`=0 gives `res_exokay`=0 and `res_strb` equal to the `wr_strb` that was presented.
- R4: An exclusive write passes (`res_exokay`=1, `res_strb`=`wr_strb`) only when a reservation held for the same ID stores exactly the same address as `wr_addr`.
- R5: A failing exclusive write gives `res_exokay`=0 and `res_strb`=0.
- R6: An exclusive write releases its own ID's reservation, whether it passes or fails, so an immediate repeat fails.
- R7: A plain write, or a passing exclusive write, drops every reservation of a different ID whose address lies in the written region. A write never drops a reservation of its own ID.
- R8: The written region is computed as follows. The first byte is `wr_addr` aligned down to 2^`wr_size` bytes. The last byte is first + (`wr_len`+1)·2^`wr_size` − 1, regardless of burst type. If first and last differ, with highest differing bit h, then bits [h+1:0] are ignored when comparing. If they do not differ, all bits are compared. Example: a reservation at 0x000 is dropped by a two-beat word write at 0x004 from another ID, because that region covers 0x000–0x01F.
- R9: An exclusive read from an ID that already holds a reservation overwrites that reservation's address, and at most one reservation exists per ID.
- R10: When all `NUM_SLOTS` reservations are held, an exclusive read from a new ID evicts the reservation whose last capture or refresh is oldest.
- R11: A failing exclusive write drops no reservation of any other ID.
- R12: When a capture and a write check happen in the same cycle, the write is evaluated against the reservations held before that cycle, and the capture is applied after it.
- R13: `NUM_SLOTS` may be set from 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Exclusive read capture strobe |
| rd_id | input | ID_W | ID of the exclusive read |
| rd_addr | input | ADDR_W | Address of the exclusive read |
| wr_valid | input | 1 | Write check strobe |
| wr_id | input | ID_W | ID of the write |
| wr_addr | input | ADDR_W | Start address of the write |
| wr_size | input | SIZE_W | log2 of bytes per beat |
| wr_len | input | LEN_W | Beats minus one |
| wr_excl | input | 1 | Write is exclusive |
| wr_strb | input | STRB_W | Byte strobes of the write |
| res_valid | output | 1 | Result valid, one cycle after `wr_valid` |
| res_exokay | output | 1 | 1 = exclusive-okay, 0 = okay |
| res_strb | output | STRB_W | Strobes to forward, zero on exclusive failure |

## Verification
The hardest state to reach from the ports is a full table whose age order has been reshuffled by refreshes and releases, followed by a capture that must evict exactly the oldest entry, possibly in the same cycle as a write that frees a slot. Scripted sequences first fill all four slots, refresh one, and evict. They then read each ID back with an exclusive write to expose which reservation survived. After that, a long run of mixed traffic is applied: six IDs compete for four slots over a small address window, with random sizes and lengths. A behavioural model compares the result port every clock during this run.

// File: rtl/xmon_pkg.sv
// Package: shared constants and the classification of a checked write.
// Assumes: nothing beyond IEEE 1800-2017.
package xmon_pkg;
    localparam int MAX_SLOTS = 4;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_PLAIN,
        WK_EX_PASS,
        WK_EX_FAIL
    } wr_kind_e;
endpackage

// File: rtl/xmon_region.sv
// Module: computes the first byte address of a write and the mask of low
// address bits to ignore when testing overlap with a reservation.
// Assumes: burst is treated as incrementing; ADDR_W >= LEN_W; arithmetic wraps.
module xmon_region #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [LEN_W-1:0]  wr_len,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] ign_mask
);
    logic [ADDR_W-1:0] size_lo;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] diff;
    logic [ADDR_W-1:0] smear;

    // Purpose: derive first/last byte, then smear the differing bits downward.
    always_comb begin
        size_lo    = ~({ADDR_W{1'b1}} << wr_size);
        first_addr = wr_addr & ~size_lo;
        span       = (ADDR_W'(wr_len) + ADDR_W'(1)) << wr_size;
        last_addr  = first_addr + span - ADDR_W'(1);
        diff       = first_addr ^ last_addr;
        smear      = diff;
        for (int s = 1; s < ADDR_W; s = s * 2) begin
            smear = smear | (smear >> s);
        end
        ign_mask = (diff == '0) ? '0 : ((smear << 1) | ADDR_W'(1));
    end
endmodule

// File: rtl/xmon_match.sv
// Module: per-slot comparators between the reservation table and the
// incoming write and capture.
// Assumes: slot fields are only meaningful where slot_valid is set.
module xmon_match #(
    parameter int N      = 4,
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32
) (
    input  logic [N-1:0]              slot_valid,
    input  logic [N-1:0][ID_W-1:0]    slot_id,
    input  logic [N-1:0][ADDR_W-1:0]  slot_addr,
    input  logic [ID_W-1:0]           wr_id,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [ADDR_W-1:0]         first_addr,
    input  logic [ADDR_W-1:0]         ign_mask,
    input  logic [ID_W-1:0]           rd_id,
    output logic [N-1:0]              own_hit,
    output logic [N-1:0]              own_exact,
    output logic [N-1:0]              region_hit,
    output logic [N-1:0]              rd_hit
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            // Purpose: same-ID slot held for the write.
            assign own_hit[g]    = slot_valid[g] && (slot_id[g] == wr_id);
            // Purpose: exact address equality for the exclusive pass test.
            assign own_exact[g]  = (slot_addr[g] == wr_addr);
            // Purpose: other-ID slot whose address lies in the written region.
            assign region_hit[g] = slot_valid[g] && (slot_id[g] != wr_id) &&
                                   (((slot_addr[g] ^ first_addr) & ~ign_mask) == '0);
            // Purpose: same-ID slot held for the capture.
            assign rd_hit[g]     = slot_valid[g] && (slot_id[g] == rd_id);
        end
    endgenerate
endmodule

// File: rtl/xmon_slots.sv
// Module: reservation table with age ranks. Releases from the write path are
// applied first, then an optional capture updates, fills or evicts a slot.
// Assumes: clr_vec only names valid slots; ranks of valid slots form 0..V-1.
module xmon_slots #(
    parameter int N      = 4,
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              clr_vec,
    input  logic                      rd_valid,
    input  logic [ID_W-1:0]           rd_id,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [N-1:0]              rd_hit,
    output logic [N-1:0]              slot_valid,
    output logic [N-1:0][ID_W-1:0]    slot_id,
    output logic [N-1:0][ADDR_W-1:0]  slot_addr
);
    localparam int AGE_W = (N > 1) ? $clog2(N) : 1;
    localparam int CNT_W = AGE_W + 1;

    logic [N-1:0]             valid_q, valid_n;
    logic [N-1:0][ID_W-1:0]   id_q, id_n;
    logic [N-1:0][ADDR_W-1:0] addr_q, addr_n;
    logic [N-1:0][AGE_W-1:0]  age_q, age_n, age_mid;
    logic [CNT_W-1:0]         drop;
    logic [CNT_W-1:0]         cnt_live;
    logic [AGE_W-1:0]         tgt;
    logic [CNT_W-1:0]         tgt_age;
    logic                     found;

    // Purpose: next table state: release, re-rank, then capture.
    always_comb begin
        valid_n = valid_q & ~clr_vec;
        id_n    = id_q;
        addr_n  = addr_q;
        for (int i = 0; i < N; i++) begin
            drop = '0;
            for (int j = 0; j < N; j++) begin
                if (valid_q[j] && clr_vec[j] && (age_q[j] < age_q[i])) begin
                    drop = drop + CNT_W'(1);
                end
            end
            age_mid[i] = valid_n[i] ? (age_q[i] - drop[AGE_W-1:0]) : '0;
        end
        cnt_live = CNT_W'($countones(valid_n));
        tgt      = '0;
        tgt_age  = '0;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && rd_hit[i] && valid_n[i]) begin
                tgt = AGE_W'(i); tgt_age = {1'b0, age_mid[i]}; found = 1'b1;
            end
        end
        if (!found && (cnt_live < CNT_W'(N))) begin
            for (int i = 0; i < N; i++) begin
                if (!found && !valid_n[i]) begin
                    tgt = AGE_W'(i); tgt_age = cnt_live; found = 1'b1;
                end
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (!found && (age_mid[i] == AGE_W'(N - 1))) begin
                    tgt = AGE_W'(i); tgt_age = {1'b0, age_mid[i]}; found = 1'b1;
                end
            end
        end
        age_n = age_mid;
        if (rd_valid) begin
            for (int i = 0; i < N; i++) begin
                if (valid_n[i] && (AGE_W'(i) != tgt) && ({1'b0, age_mid[i]} < tgt_age)) begin
                    age_n[i] = age_mid[i] + AGE_W'(1);
                end
            end
            valid_n[tgt] = 1'b1;
            id_n[tgt]    = rd_id;
            addr_n[tgt]  = rd_addr;
            age_n[tgt]   = '0;
        end
    end

    // Purpose: table registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            id_q    <= '0;
            addr_q  <= '0;
            age_q   <= '0;
        end else begin
            valid_q <= valid_n;
            id_q    <= id_n;
            addr_q  <= addr_n;
            age_q   <= age_n;
        end
    end

    assign slot_valid = valid_q;
    assign slot_id    = id_q;
    assign slot_addr  = addr_q;

    logic dup_id;
    logic rank_bad;
    logic [CNT_W-1:0] live_q;
    // Purpose: invariant flags watched by the assertions below.
    always_comb begin
        dup_id   = 1'b0;
        rank_bad = 1'b0;
        live_q   = CNT_W'($countones(valid_q));
        for (int i = 0; i < N; i++) begin
            if (valid_q[i] && ({1'b0, age_q[i]} >= live_q)) rank_bad = 1'b1;
            for (int j = i + 1; j < N; j++) begin
                if (valid_q[i] && valid_q[j] && (id_q[i] == id_q[j])) dup_id = 1'b1;
            end
        end
    end

    AST_ID_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) !dup_id); // R9
    AST_RANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) !rank_bad); // R10
endmodule

// File: rtl/excl_monitor.sv
// Module: top of the exclusive access monitor. Classifies each checked write,
// releases reservations and registers the result one cycle later.
// Assumes: one write check and one capture at most per cycle; 1 <= NUM_SLOTS <= 4.
module excl_monitor
    import xmon_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int SIZE_W    = 3,
    parameter int STRB_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic              wr_excl,
    input  logic [STRB_W-1:0] wr_strb,
    output logic              res_valid,
    output logic              res_exokay,
    output logic [STRB_W-1:0] res_strb
);
    localparam int N = NUM_SLOTS;

    initial begin
        AST_SLOT_RANGE: assert (N >= 1 && N <= MAX_SLOTS); // R13
    end

    logic [ADDR_W-1:0]        first_addr, ign_mask;
    logic [N-1:0]             slot_valid;
    logic [N-1:0][ID_W-1:0]   slot_id;
    logic [N-1:0][ADDR_W-1:0] slot_addr;
    logic [N-1:0]             own_hit, own_exact, region_hit, rd_hit;
    logic [N-1:0]             clr_vec;
    logic                     excl_pass;
    wr_kind_e                 kind;

    xmon_region #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_region (
        .wr_addr    (wr_addr),
        .wr_size    (wr_size),
        .wr_len     (wr_len),
        .first_addr (first_addr),
        .ign_mask   (ign_mask)
    );

    xmon_match #(.N(N), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_match (
        .slot_valid (slot_valid),
        .slot_id    (slot_id),
        .slot_addr  (slot_addr),
        .wr_id      (wr_id),
        .wr_addr    (wr_addr),
        .first_addr (first_addr),
        .ign_mask   (ign_mask),
        .rd_id      (rd_id),
        .own_hit    (own_hit),
        .own_exact  (own_exact),
        .region_hit (region_hit),
        .rd_hit     (rd_hit)
    );

    // Purpose: classify the write and choose which reservations to release.
    always_comb begin
        excl_pass = |(own_hit & own_exact);
        kind      = WK_IDLE;
        if (wr_valid) begin
            if (!wr_excl)       kind = WK_PLAIN;
            else if (excl_pass) kind = WK_EX_PASS;
            else                kind = WK_EX_FAIL;
        end
        clr_vec = '0;
        if (kind == WK_EX_PASS || kind == WK_EX_FAIL) clr_vec = clr_vec | own_hit;
        if (kind == WK_PLAIN   || kind == WK_EX_PASS) clr_vec = clr_vec | region_hit;
    end

    xmon_slots #(.N(N), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_vec    (clr_vec),
        .rd_valid   (rd_valid),
        .rd_id      (rd_id),
        .rd_addr    (rd_addr),
        .rd_hit     (rd_hit),
        .slot_valid (slot_valid),
        .slot_id    (slot_id),
        .slot_addr  (slot_addr)
    );

    // Purpose: register the response and the strobes to forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_exokay <= 1'b0;
            res_strb   <= '0;
        end else begin
            res_valid  <= (kind != WK_IDLE);
            res_exokay <= (kind == WK_EX_PASS);
            res_strb   <= (kind == WK_PLAIN || kind == WK_EX_PASS) ? wr_strb : '0;
        end
    end

    AST_RES_TIMING: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |=> res_valid); // R2
    AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !wr_valid |=> !res_valid); // R2
    AST_PLAIN_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_excl) |=> (!res_exokay && res_strb == $past(wr_strb))); // R3
    AST_PASS_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_excl && own_hit == '0) |=> !res_exokay); // R4
    AST_FAIL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_excl) |=> (res_exokay || res_strb == '0)); // R5
    AST_EXCL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_excl && !rd_valid) |=> ((slot_valid & $past(own_hit)) == '0)); // R6
    AST_OWN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(own_hit)); // R9
endmodule

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [3:0]  rd_id = '0;
    logic [31:0] rd_addr = '0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_id = '0;
    logic [31:0] wr_addr = '0;
    logic [2:0]  wr_size = '0;
    logic [7:0]  wr_len = '0;
    logic        wr_excl = 1'b0;
    logic [3:0]  wr_strb = '0;
    logic        res_valid;
    logic        res_exokay;
    logic [3:0]  res_strb;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    excl_monitor u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_len(wr_len), .wr_excl(wr_excl), .wr_strb(wr_strb),
        .res_valid(res_valid), .res_exokay(res_exokay), .res_strb(res_strb)
    );

    // behavioural reference: four reservations, age order kept in a queue
    bit          mv[4];
    logic [3:0]  mid[4];
    logic [31:0] maddr[4];
    int          ord[$];

    function automatic logic [31:0] first_of(logic [31:0] a, logic [2:0] sz);
        longint unsigned al = (longint'(1) << sz) - 1;
        return a & ~al[31:0];
    endfunction

    function automatic logic [31:0] mask_of(logic [31:0] a, logic [2:0] sz, logic [7:0] ln);
        logic [31:0] f = first_of(a, sz);
        logic [31:0] l = f + ((32'(ln) + 32'd1) << sz) - 32'd1;
        logic [31:0] d = f ^ l;
        int hb = -1;
        longint unsigned m;
        for (int b = 0; b < 32; b++) if (d[b]) hb = b;
        if (hb < 0) return 32'd0;
        m = (longint'(1) << (hb + 2)) - 1;
        return m[31:0];
    endfunction

    task automatic rel(int s);
        mv[s] = 1'b0;
        for (int k = 0; k < ord.size(); k++) if (ord[k] == s) begin ord.delete(k); break; end
    endtask

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(bit rv, logic [3:0] rid, logic [31:0] ra,
                        bit wv, logic [3:0] wid, logic [31:0] wa, logic [2:0] ws,
                        logic [7:0] wl, bit wx, logic [3:0] wsb);
        bit e_ok; logic [3:0] e_strb; bit wrote; int s;
        logic [31:0] m, f;
        @(negedge clk);
        rd_valid = rv; rd_id = rid; rd_addr = ra;
        wr_valid = wv; wr_id = wid; wr_addr = wa; wr_size = ws; wr_len = wl;
        wr_excl = wx; wr_strb = wsb;
        e_ok = 1'b0; e_strb = '0;
        if (wv) begin
            s = -1;
            for (int i = 0; i < 4; i++) if (mv[i] && mid[i] == wid) s = i;
            if (wx) begin
                e_ok = (s >= 0) && (maddr[s] == wa);
                e_strb = e_ok ? wsb : 4'h0;
                if (s >= 0) rel(s);
                wrote = e_ok;
            end else begin
                e_strb = wsb; wrote = 1'b1;
            end
            if (wrote) begin
                m = mask_of(wa, ws, wl); f = first_of(wa, ws);
                for (int i = 0; i < 4; i++)
                    if (mv[i] && mid[i] != wid && ((maddr[i] ^ f) & ~m) == 0) rel(i);
            end
        end
        if (rv) begin
            s = -1;
            for (int i = 0; i < 4; i++) if (mv[i] && mid[i] == rid) s = i;
            if (s >= 0) rel(s);
            else for (int i = 3; i >= 0; i--) if (!mv[i]) s = i;
            if (s < 0) begin s = ord.pop_front(); mv[s] = 1'b0; end
            mv[s] = 1'b1; mid[s] = rid; maddr[s] = ra; ord.push_back(s);
        end
        @(posedge clk);
        #1;
        check("res_valid", 32'(res_valid), 32'(wv));
        if (wv) begin
            check("res_exokay", 32'(res_exokay), 32'(e_ok));
            check("res_strb", 32'(res_strb), 32'(e_strb));
        end
    endtask

    task automatic xrd(logic [3:0] id, logic [31:0] a);
        step(1, id, a, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wex(logic [3:0] id, logic [31:0] a);
        step(0, 0, 0, 1, id, a, 3'd2, 8'd0, 1, 4'hF);
    endtask
    task automatic wpl(logic [3:0] id, logic [31:0] a, logic [2:0] sz, logic [7:0] ln, logic [3:0] sb);
        step(0, 0, 0, 1, id, a, sz, ln, 0, sb);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        check("res_valid in reset", 32'(res_valid), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);      // R1 idle after reset
        wex(4'd0, 32'h0);                          // R1 nothing held -> fail
        cur_req = "R2";
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        cur_req = "R4";  xrd(0, 32'h000); wex(0, 32'h000);
        cur_req = "R6";  wex(0, 32'h000);
        cur_req = "R3";  wpl(1, 32'h80, 3'd2, 8'd0, 4'hA); wpl(2, 32'h84, 3'd1, 8'd3, 4'h3);
        cur_req = "R5";  xrd(0, 32'h010); wex(0, 32'h014);

        cur_req = "R8";  xrd(0, 32'h000); wpl(1, 32'h004, 3'd2, 8'd1, 4'hF); wex(0, 32'h000);
        cur_req = "R8";  xrd(0, 32'h000); wpl(1, 32'h040, 3'd2, 8'd0, 4'hF); wex(0, 32'h000);
        cur_req = "R8";  xrd(2, 32'h060); wpl(1, 32'h01C, 3'd2, 8'd1, 4'hF); wex(2, 32'h060);
        cur_req = "R8";  xrd(2, 32'h041); wpl(1, 32'h040, 3'd0, 8'd0, 4'h1); wex(2, 32'h041);
        cur_req = "R8";  xrd(2, 32'h0A0); wpl(1, 32'h0A8, 3'd2, 8'd0, 4'hF); wex(2, 32'h0A0);

        cur_req = "R7";  xrd(2, 32'h100); wpl(2, 32'h100, 3'd2, 8'd0, 4'hF); wex(2, 32'h100);
        cur_req = "R7";  xrd(2, 32'h100); wpl(3, 32'h100, 3'd2, 8'd0, 4'hF); wex(2, 32'h100);

        cur_req = "R9";  xrd(3, 32'h200); xrd(3, 32'h300); wex(3, 32'h300);
        cur_req = "R9";  xrd(3, 32'h200); xrd(3, 32'h300); wex(3, 32'h200);

        cur_req = "R10"; xrd(1, 32'h10); xrd(2, 32'h20); xrd(3, 32'h30); xrd(4, 32'h40);
        xrd(5, 32'h50); wex(1, 32'h10); wex(2, 32'h20); wex(5, 32'h50);
        cur_req = "R10"; xrd(1, 32'h10); xrd(2, 32'h20); xrd(3, 32'h30); xrd(4, 32'h40);
        xrd(1, 32'h10); xrd(6, 32'h60); wex(1, 32'h10); wex(2, 32'h20);

        cur_req = "R11"; xrd(6, 32'h500); wex(7, 32'h500); wex(6, 32'h500);
        cur_req = "R11"; xrd(6, 32'h600); xrd(7, 32'h600); wex(7, 32'h600); wex(6, 32'h600);

        cur_req = "R12"; step(1, 8, 32'h700, 1, 8, 32'h700, 3'd2, 8'd0, 1, 4'hF); wex(8, 32'h700);
        cur_req = "R12"; xrd(9, 32'h720);
        step(1, 9, 32'h740, 1, 9, 32'h720, 3'd2, 8'd0, 1, 4'hF); wex(9, 32'h740);

        cur_req = "R4,R7,R10 mixed";
        for (int n = 0; n < 3000; n++) begin
            bit rv = ($urandom % 3) == 0;
            bit wv = ($urandom % 2) == 0;
            bit wx = ($urandom % 2) == 0;
            logic [3:0]  rid = 4'($urandom % 6);
            logic [3:0]  wid = 4'($urandom % 6);
            logic [31:0] ra  = 32'(($urandom % 16) * 4);
            logic [31:0] wa  = wx ? 32'(($urandom % 16) * 4) : 32'($urandom % 64);
            logic [2:0]  ws  = wx ? 3'd2 : 3'($urandom % 3);
            logic [7:0]  wl  = wx ? 8'd0 : 8'($urandom % 4);
            step(rv, rid, ra, wv, wid, wa, ws, wl, wx, 4'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule